// File: doc/BRIEF.md
# CIC Interpolating Up-Mixer

This block is the last stage of a digital up converter. Complex baseband samples that earlier filter stages have already brought to 200 kHz enter on a valid strobe. A four-section cascaded integrator-comb interpolator raises the rate by ten to 2 MHz. A numerically controlled oscillator then moves the result to an intermediate frequency, and the block emits the real passband sample once per output clock enable.

The comb sections run at the input rate and update only on accepted samples. The integrator sections run at the output rate and update on each clock enable. All filter arithmetic wraps in two's complement. The oscillator is a 32-bit phase accumulator that advances by a tuning word on every enable. Its top bits address a 256-point cosine/sine wheel, which is built at elaboration from a quarter-wave table. For a 455 kHz IF in a 2 MHz stream, the tuning word is 977105060, which is round(455e3/2e6 * 2^32).

Top module: `cic_upmixer`

## Requirements
- R1: A synchronous reset clears the comb delays, the integrators, the pending-sample flag, the phase accumulator and the output register. After reset, out_data is 0 and out_valid is 0.
- R2: out_valid is high in exactly those cycles that follow a cycle in which ce was high.
- R3: Hold I constant at an input, with Q arbitrary and the tuning word at 0. After the filter fills, out_data settles to round(I * 10^3 * 32767 / 2^25).
- R4: A single input sample followed by zero samples produces the fourth power of a 10-tap boxcar at the output rate, 37 taps long. Its first tap appears 4 enables after the enable that consumed the sample.
- R5: The phase starts at 0 and gains tune_word, modulo 2^32, at each enable. The output produced at enable m uses the sum of the tuning words seen at enables 0..m-1. Bits 31..24 of that sum select point k of a 256-point wheel, cos/sin(2*pi*k/256).
- R6: out_data equals round((I*cos - Q*sin) / 2^25), within 3 LSB. Here I and Q are the integrator outputs and cos and sin have amplitude 32767.
- R7: The rounded mixer result is saturated to the range [-32768, 32767].
- R8: A sample presented with in_valid enters the integrators at the first enable in a later cycle. A sample presented in the same cycle as an enable therefore waits for the following enable. No new sample may arrive while an earlier one is still waiting.
- R9: In cycles without ce, out_data and the phase hold their values.
- R10: A new tune_word value takes effect at the next enable. Earlier phase increments are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Output-rate clock enable (2 MHz) |
| in_valid | input | 1 | Input sample strobe, at most one per ten enables |
| in_i | input | 16 | In-phase input sample, signed |
| in_q | input | 16 | Quadrature input sample, signed |
| tune_word | input | 32 | Phase increment per enable |
| out_valid | output | 1 | Strobe one cycle after each enable |
| out_data | output | 16 | Real passband sample, signed |

## Verification
A wrong comb delay or integrator value has two visible effects. It distorts the whole 37-tap response, which shows up within a few enables of a sample arriving, or it leaves a DC offset that never decays. A wrong phase or wheel entry changes the mixed output at the very next enable. Because the oscillator sweeps the wheel continuously, a bad quadrant shows up within four enables at a quarter-turn tuning word. A wrong hand-off of the pending sample shifts every response by one enable. That shift is visible as soon as the impulse edge reaches the output.

// File: rtl/cic_upmixer.sv
module cic_upmixer #(
  parameter int DW     = 16,
  parameter int N_SEC  = 4,
  parameter int RATE   = 10,
  parameter int PW     = 32,
  parameter int LUT_AW = 8,
  parameter int CW     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [PW-1:0]        tune_word,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);

  localparam int GROW = $clog2(RATE ** (N_SEC - 1));
  localparam int IW   = DW + GROW;
  localparam int QN   = 2 ** (LUT_AW - 2);
  localparam int SH   = GROW + CW - 1;
  localparam int PWD  = IW + CW + 1;
  localparam longint AMP = (longint'(1) << (CW - 1)) - 1;
  localparam logic signed [PWD-1:0] HALF = PWD'(longint'(1) << (SH - 1));
  localparam logic signed [DW-1:0] OMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] OMIN = {1'b1, {(DW-1){1'b0}}};

  // quarter-wave sine sample k of QN, Taylor series in Q28 fixed point
  function automatic longint sine_q(input int k);
    longint x, x2, term, sum;
    x    = 64'sd843314857 * k / (2 * QN);
    x2   = (x * x) >>> 28;
    term = x;
    sum  = x;
    for (int n = 1; n <= 6; n++) begin
      term = -((term * x2) >>> 28) / ((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return (sum * AMP + (64'sd1 <<< 27)) >>> 28;
  endfunction

  logic signed [CW-1:0] qtab [QN+1];
  for (genvar k = 0; k <= QN; k++) begin : g_tab
    localparam logic signed [CW-1:0] V = CW'(sine_q(k));
    assign qtab[k] = V;
  end

  function automatic logic signed [CW-1:0] wheel(input logic [LUT_AW-1:0] a);
    int ix;
    logic signed [CW-1:0] v;
    ix = int'(a[LUT_AW-3:0]);
    v  = a[LUT_AW-2] ? qtab[QN - ix] : qtab[ix];
    return a[LUT_AW-1] ? -v : v;
  endfunction

  logic                 pend;
  logic [PW-1:0]        phase;
  logic signed [DW-1:0] din   [2];
  logic signed [IW-1:0] cic_y [2];

  assign din[0] = in_i;
  assign din[1] = in_q;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= in_valid | (pend & ~ce);
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic signed [IW-1:0] cd  [N_SEC+1];
    logic signed [IW-1:0] cz  [N_SEC];
    logic signed [IW-1:0] acc [N_SEC];
    logic signed [IW-1:0] cout;

    assign cd[0] = IW'(din[ch]);
    for (genvar s = 0; s < N_SEC; s++) begin : g_comb
      assign cd[s+1] = cd[s] - cz[s];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < N_SEC; s++) begin
          cz[s]  <= '0;
          acc[s] <= '0;
        end
        cout <= '0;
      end else begin
        if (in_valid) begin
          for (int s = 0; s < N_SEC; s++) cz[s] <= cd[s];
          cout <= cd[N_SEC];
        end
        if (ce) begin
          acc[0] <= acc[0] + (pend ? cout : '0);
          for (int s = 1; s < N_SEC; s++) acc[s] <= acc[s] + acc[s-1];
        end
      end
    end

    assign cic_y[ch] = acc[N_SEC-1];
  end

  logic [LUT_AW-1:0]     pa;
  logic signed [CW-1:0]  cosv, sinv;
  logic signed [PWD-1:0] mix, rnd;
  logic signed [DW-1:0]  sat;

  assign pa   = phase[PW-1 -: LUT_AW];
  assign sinv = wheel(pa);
  assign cosv = wheel(pa + LUT_AW'(QN));
  assign mix  = PWD'(cic_y[0]) * PWD'(cosv) - PWD'(cic_y[1]) * PWD'(sinv);
  assign rnd  = (mix + HALF) >>> SH;

  always_comb begin
    if (rnd > PWD'(OMAX))      sat = OMAX;
    else if (rnd < PWD'(OMIN)) sat = OMIN;
    else                       sat = rnd[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      phase     <= '0;
    end else begin
      out_valid <= ce;
      if (ce) begin
        out_data <= sat;
        phase    <= phase + tune_word;
      end
    end
  end

  assert_valid_after_ce_R2: assert property (@(posedge clk) disable iff (rst)
    ce |=> out_valid);
  assert_no_valid_without_ce_R2: assert property (@(posedge clk) disable iff (rst)
    !ce |=> !out_valid);
  assert_hold_between_enables_R9: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(out_data) && $stable(phase)));
  assert_single_pending_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (!pend || ce));

endmodule

// File: tb/cic_upmixer_bench.sv
module cic_upmixer_bench;
  localparam int DW = 16, NS = 4, RT = 10, PW = 32, AW = 8, CW = 16;
  localparam int HL = NS * (RT - 1) + 1;
  localparam int MAXS = 512;
  localparam int TOL = 3;
  localparam logic [31:0] TW_IF = 32'd977105060;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, ce, in_valid;
  logic signed [DW-1:0] in_i, in_q;
  logic [PW-1:0] tune_word;
  logic out_valid;
  logic signed [DW-1:0] out_data;

  cic_upmixer u_cic_upmixer (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .tune_word(tune_word),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  longint h [HL];
  int xi [MAXS+2];
  int xq [MAXS+2];
  int m;
  longint ph;
  int unsigned seed = 32'd12345;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (step %0d)", req, act, exp, m);
    end
  endtask

  function automatic int lcg_val(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % (2 * span + 1)) - span;
  endfunction

  function automatic longint expect_out(input int mm, input longint p);
    longint ci = 0, cq = 0;
    int a;
    real th, y, yr;
    for (int j = 0; j < HL; j++) begin
      if (mm - 4 - j >= 0) begin
        ci += h[j] * xi[mm-4-j];
        cq += h[j] * xq[mm-4-j];
      end
    end
    a  = int'((p >> 24) & 255);
    th = 2.0 * 3.14159265358979 * a / 256.0;
    y  = (real'(ci) * 32767.0 * $cos(th) - real'(cq) * 32767.0 * $sin(th)) / 33554432.0;
    yr = $floor(y + 0.5);
    if (yr > 32767.0) yr = 32767.0;
    if (yr < -32768.0) yr = -32768.0;
    return longint'(yr);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; ce = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int k = 0; k < MAXS + 2; k++) begin xi[k] = 0; xq[k] = 0; end
    m = 0; ph = 0;
    check(out_data == 0, "R1 data", longint'(out_data), 0);
    check(out_valid == 0, "R1 valid", longint'(out_valid), 0);
  endtask

  task automatic step(input bit inj, input int vi, input int vq, input bit coinc, input string req);
    longint e;
    logic signed [DW-1:0] held;
    if (inj) begin
      xi[coinc ? m + 1 : m] = vi;
      xq[coinc ? m + 1 : m] = vq;
    end
    @(negedge clk);
    in_valid = inj && !coinc; in_i = DW'(vi); in_q = DW'(vq); ce = 0;
    @(negedge clk);
    in_valid = inj && coinc; ce = 1;
    @(negedge clk);
    in_valid = 0; ce = 0;
    e = expect_out(m, ph);
    check(out_valid == 1, "R2 valid after enable", longint'(out_valid), 1);
    check((longint'(out_data) - e <= TOL) && (e - longint'(out_data) <= TOL), req,
          longint'(out_data), e);
    held = out_data;
    ph = (ph + longint'(tune_word)) & 64'hFFFF_FFFF;
    @(negedge clk);
    check(out_valid == 0, "R2 idle valid", longint'(out_valid), 0);
    check(out_data == held, "R9 hold", longint'(out_data), longint'(held));
    m++;
  endtask

  initial begin
    longint tmp [HL];
    rst = 1; ce = 0; in_valid = 0; in_i = 0; in_q = 0; tune_word = 0;
    for (int j = 0; j < HL; j++) h[j] = (j == 0) ? 1 : 0;
    for (int s = 0; s < NS; s++) begin
      for (int j = 0; j < HL; j++) begin
        tmp[j] = 0;
        for (int k = 0; k < RT; k++) if (j - k >= 0) tmp[j] += h[j-k];
      end
      for (int j = 0; j < HL; j++) h[j] = tmp[j];
    end

    // R3: DC gain at zero tuning word, Q has no effect
    do_reset();
    tune_word = 0;
    for (int k = 0; k < 80; k++) step(k % RT == 0, 10000, 7000, 0, "R3 DC");
    check((out_data >= 9765 - 1) && (out_data <= 9765 + 1), "R3 settled",
          longint'(out_data), 9765);

    // R4: impulse response
    do_reset();
    tune_word = 0;
    for (int k = 0; k < 60; k++) step(k % RT == 0, (k == 0) ? 30000 : 0, 0, 0, "R4 impulse");

    // R5/R6/R10: IF tuning word, varying I/Q, tuning change mid-run
    do_reset();
    tune_word = TW_IF;
    for (int k = 0; k < 300; k++) begin
      if (k == 150) tune_word = 32'h9000_0123;
      step(k % RT == 0, lcg_val(12000), lcg_val(12000), 0, (k < 150) ? "R6 mix" : "R10 retune");
    end

    // R5: quarter-turn phase steps exercise all quadrants
    do_reset();
    tune_word = 32'h4000_0000;
    for (int k = 0; k < 60; k++) step(k % RT == 0, 9000, -4000, 0, "R5 phase");

    // R7: saturation with large inputs
    do_reset();
    tune_word = 32'h2000_0000;
    for (int k = 0; k < 80; k++) step(k % RT == 0, 32000, -32000, 0, "R7 saturate");

    // R8: sample coincident with an enable waits for the next one
    do_reset();
    tune_word = TW_IF;
    for (int k = 0; k < 120; k++) step(k % RT == RT - 1, lcg_val(15000), lcg_val(15000), 1, "R8 coincident");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule